// File: doc/BRIEF.md
# Serial Controller Register File with Divisor Latch

This block decodes the byte-wide register bus of a legacy PC-style serial controller. A 3-bit offset selects one of eight register slots. Write and read strobes are applied for one cycle. The block holds five registers: line control, scratch, FIFO control, the two divisor bytes, and the overrun flag of the line status. It also drives the control strobes of an external receive FIFO: clear with a depth select, push, and pop.

Bit 7 of line control turns offsets 0 and 1 into the low and high divisor bytes. The divisor resets to the value that gives 115200 baud from a 1.8432 MHz reference. When the loopback input is high, bytes written to the data slot are pushed into the receive FIFO. A write that finds the FIFO full is dropped and raises overrun. Read data is combinational from the offset, so it is valid in the cycle of the read strobe. The read side effects (pop, overrun clear) take effect at the clock edge that ends the read.

Top module: `sio_regbank`

## Requirements
- R1: After reset, `divisor` is 0x0001, `line_ctl` is 0x00, `fifo_ctl` is 0x00, scratch reads 0x00 and overrun is clear.
- R2: With `line_ctl[7]` set, offset 0 reads and writes the low divisor byte (`divisor[7:0]`) and offset 1 the high byte (`divisor[15:8]`). Neither access pushes or pops the FIFO.
- R3: With `line_ctl[7]` clear, a write to offset 1 leaves the divisor unchanged. Reads of offsets 1, 2, 4 and 6 return 0xFF.
- R4: Offset 3 is line control and offset 7 is scratch. Each reads back the last byte written to it.
- R5: A write to offset 2 with bit 0 clear makes `fifo_ctl` 0x00. With bit 0 set it stores the written byte AND 0xC9: bit 0 enable, bit 3 DMA mode, bits 7:6 trigger level.
- R6: An offset-2 write that changes the enable bit pulses `fifo_clr` in its cycle, with `fifo_deep` equal to the new enable value. An offset-2 write with bits 0 and 1 both set also pulses `fifo_clr`, with `fifo_deep` = 1. Any other offset-2 write leaves `fifo_clr` low.
- R7: A data write (offset 0, `line_ctl[7]` clear) with `loop_en` high and `fifo_full` low pulses `fifo_push`, with `fifo_wdata` equal to the written byte. With `loop_en` low there is no push.
- R8: A loopback data write while `fifo_full` is high does not push and sets overrun.
- R9: The line status at offset 5 reads 0x60, plus 0x02 when overrun is set, plus 0x01 when `fifo_empty` is low. A read clears overrun. Writes to offset 5 change nothing.
- R10: A data read (offset 0, `line_ctl[7]` clear) returns `fifo_rdata` and pulses `fifo_pop` when the FIFO is nonempty. When the FIFO is empty it returns 0x00 and does not pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_off | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| loop_en | input | 1 | Loopback mode from modem control |
| fifo_empty | input | 1 | Receive FIFO empty |
| fifo_full | input | 1 | Receive FIFO full |
| fifo_rdata | input | 8 | Receive FIFO head byte |
| fifo_push | output | 1 | Push strobe |
| fifo_wdata | output | 8 | Byte to push |
| fifo_pop | output | 1 | Pop strobe |
| fifo_clr | output | 1 | Clear strobe |
| fifo_deep | output | 1 | Depth select: 1 full size, 0 one entry |
| fifo_ctl | output | 8 | Stored FIFO control value |
| line_ctl | output | 8 | Line control value |
| divisor | output | 16 | Baud divisor |

## Verification
The register slots are first walked with a table of write/read-back pairs. The table alternates the divisor-latch bit, so that the same offsets must resolve to divisor bytes in one row and to foreign or data slots in the next. The FIFO control port gets a sequence of values that turns the enable bit on, off and back, with and without the receiver-reset bit and with extra bits present. This separates a clear caused by a change of mode from one caused by a reset request, and tests the storage mask. Data writes and reads are tried with every combination of loopback, full and empty. This separates push, drop-with-overrun and pop, and shows that overrun is cleared by the status read.

// File: rtl/sio_regbank.sv
module sio_regbank #(
  parameter int REF_HZ = 1843200,
  parameter int BAUD   = 115200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_off,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        loop_en,
  input  logic        fifo_empty,
  input  logic        fifo_full,
  input  logic [7:0]  fifo_rdata,
  output logic        fifo_push,
  output logic [7:0]  fifo_wdata,
  output logic        fifo_pop,
  output logic        fifo_clr,
  output logic        fifo_deep,
  output logic [7:0]  fifo_ctl,
  output logic [7:0]  line_ctl,
  output logic [15:0] divisor
);
  localparam int          DIV_RST  = REF_HZ / BAUD / 16;
  localparam logic [15:0] DIV_INIT = 16'(DIV_RST);
  localparam logic [7:0]  FC_MASK  = 8'hC9;

  logic [7:0] lcr_q, scr_q, fcr_q, dll_q, dlh_q;
  logic       ovr_q;

  wire dlab    = lcr_q[7];
  wire at_data = (reg_off == 3'd0) && !dlab;
  wire wr_dll  = reg_wr && (reg_off == 3'd0) && dlab;
  wire wr_dlh  = reg_wr && (reg_off == 3'd1) && dlab;
  wire wr_fcr  = reg_wr && (reg_off == 3'd2);
  wire rd_lsr  = reg_rd && (reg_off == 3'd5);
  wire tx_loop = reg_wr && at_data && loop_en;
  wire ovr_set = tx_loop && fifo_full;

  assign fifo_push  = tx_loop && !fifo_full;
  assign fifo_wdata = reg_wdata;
  assign fifo_pop   = reg_rd && at_data && !fifo_empty;
  assign fifo_clr   = wr_fcr && ((reg_wdata[0] ^ fcr_q[0]) || (reg_wdata[0] && reg_wdata[1]));
  assign fifo_deep  = wr_fcr ? reg_wdata[0] : fcr_q[0];
  assign fifo_ctl   = fcr_q;
  assign line_ctl   = lcr_q;
  assign divisor    = {dlh_q, dll_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr_q <= '0;
      scr_q <= '0;
      fcr_q <= '0;
      dll_q <= DIV_INIT[7:0];
      dlh_q <= DIV_INIT[15:8];
      ovr_q <= 1'b0;
    end else begin
      if (wr_dll) dll_q <= reg_wdata;
      if (wr_dlh) dlh_q <= reg_wdata;
      if (wr_fcr) fcr_q <= reg_wdata[0] ? (reg_wdata & FC_MASK) : 8'h00;
      if (reg_wr && reg_off == 3'd3) lcr_q <= reg_wdata;
      if (reg_wr && reg_off == 3'd7) scr_q <= reg_wdata;
      if (ovr_set) ovr_q <= 1'b1;
      else if (rd_lsr) ovr_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_off)
      3'd0:    reg_rdata = dlab ? dll_q : (fifo_empty ? 8'h00 : fifo_rdata);
      3'd1:    reg_rdata = dlab ? dlh_q : 8'hFF;
      3'd3:    reg_rdata = lcr_q;
      3'd5:    reg_rdata = {1'b0, 1'b1, 1'b1, 3'b000, ovr_q, !fifo_empty};
      3'd7:    reg_rdata = scr_q;
      default: reg_rdata = 8'hFF;
    endcase
  end

  p_no_pop_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);
  p_no_push_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> (!fifo_full && loop_en));
  p_dlab_no_fifo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    line_ctl[7] |-> !(fifo_push || fifo_pop));
  p_fcr_off_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_off == 3'd2 && !reg_wdata[0]) |=> (fifo_ctl == 8'h00));
  p_mode_change_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_off == 3'd2 && (reg_wdata[0] != fifo_ctl[0])) |-> (fifo_clr && fifo_deep == reg_wdata[0]));
  p_ovr_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_off == 3'd5 && !(reg_wr && reg_off == 3'd0)) |=> (reg_off != 3'd5 || reg_rdata[1] == 1'b0));
  p_div_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !line_ctl[7] |=> $stable(divisor));
endmodule

// File: tb/test_sio_regbank.sv
`timescale 1ns/1ps
module test_sio_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_off = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        loop_en = 1'b0, fifo_empty = 1'b1, fifo_full = 1'b0;
  logic [7:0]  fifo_rdata = '0;
  logic        fifo_push, fifo_pop, fifo_clr, fifo_deep;
  logic [7:0]  fifo_wdata, fifo_ctl, line_ctl;
  logic [15:0] divisor;

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  logic       c_push, c_clr, c_deep, c_pop;
  logic [7:0] c_fwd, c_rd;

  always #2.5 clk = ~clk;

  sio_regbank i_sio_regbank (.*);

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] o, input logic [7:0] d);
    @(negedge clk);
    reg_off = o; reg_wdata = d; reg_wr = 1'b1;
    #1;
    c_push = fifo_push; c_clr = fifo_clr; c_deep = fifo_deep; c_fwd = fifo_wdata;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] o);
    @(negedge clk);
    reg_off = o; reg_rd = 1'b1;
    #1;
    c_rd = reg_rdata; c_pop = fifo_pop;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // {offset, write byte, expected read-back}
  localparam logic [18:0] VEC [12] = '{
    {3'd7, 8'hA5, 8'hA5}, {3'd7, 8'h5A, 8'h5A}, {3'd3, 8'h1B, 8'h1B},
    {3'd3, 8'h83, 8'h83}, {3'd0, 8'h34, 8'h34}, {3'd1, 8'h12, 8'h12},
    {3'd3, 8'h03, 8'h03}, {3'd1, 8'h77, 8'hFF}, {3'd5, 8'hFF, 8'h60},
    {3'd4, 8'h00, 8'hFF}, {3'd6, 8'h3C, 8'hFF}, {3'd0, 8'h55, 8'h00}
  };

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(divisor == 16'h0001, "R1 divisor", divisor, 16'h0001);
    chk(line_ctl == 8'h00 && fifo_ctl == 8'h00, "R1 lcr/fcr", {line_ctl, fifo_ctl}, 16'h0000);
    rd(3'd7); chk(c_rd == 8'h00, "R1 scratch", c_rd, 8'h00);
    rd(3'd5); chk(c_rd == 8'h60, "R1 status", c_rd, 8'h60);

    // R2 R3 R4 R9 R10 table walk
    for (int i = 0; i < 12; i++) begin
      wr(VEC[i][18:16], VEC[i][15:8]);
      rd(VEC[i][18:16]);
      chk(c_rd == VEC[i][7:0], $sformatf("R2/R3/R4 vector %0d", i), c_rd, VEC[i][7:0]);
    end
    chk(divisor == 16'h1234, "R3 divisor kept after offset-1 write", divisor, 16'h1234);

    // R5 R6 FIFO control
    wr(3'd2, 8'h01);
    chk(c_clr && c_deep, "R6 enable clears deep", {c_clr, c_deep}, 2'b11);
    chk(fifo_ctl == 8'h01, "R5 enable stored", fifo_ctl, 8'h01);
    wr(3'd2, 8'hCF);
    chk(c_clr && c_deep, "R6 receiver reset", {c_clr, c_deep}, 2'b11);
    chk(fifo_ctl == 8'hC9, "R5 mask", fifo_ctl, 8'hC9);
    wr(3'd2, 8'h09);
    chk(!c_clr, "R6 no clear", c_clr, 1'b0);
    chk(fifo_ctl == 8'h09, "R5 dma kept", fifo_ctl, 8'h09);
    wr(3'd2, 8'hC8);
    chk(c_clr && !c_deep, "R6 disable clears shallow", {c_clr, c_deep}, 2'b10);
    chk(fifo_ctl == 8'h00, "R5 disable zero", fifo_ctl, 8'h00);
    wr(3'd2, 8'h02);
    chk(!c_clr && fifo_ctl == 8'h00, "R6 stay off", {c_clr, fifo_ctl}, 9'h000);

    // R7 R8 loopback push and overrun
    loop_en = 1'b1; fifo_full = 1'b0;
    wr(3'd0, 8'h3C);
    chk(c_push && c_fwd == 8'h3C, "R7 loop push", {c_push, c_fwd}, 9'h13C);
    loop_en = 1'b0;
    wr(3'd0, 8'h44);
    chk(!c_push, "R7 no loop no push", c_push, 1'b0);
    rd(3'd5); chk(c_rd == 8'h60, "R7 no overrun without loop", c_rd, 8'h60);
    loop_en = 1'b1; fifo_full = 1'b1;
    wr(3'd0, 8'h99);
    chk(!c_push, "R8 full no push", c_push, 1'b0);
    wr(3'd5, 8'h00);
    rd(3'd5); chk(c_rd == 8'h62, "R8 overrun set, R9 write ignored", c_rd, 8'h62);
    rd(3'd5); chk(c_rd == 8'h60, "R9 overrun cleared", c_rd, 8'h60);
    loop_en = 1'b0; fifo_full = 1'b0;

    // R10 data reads
    fifo_empty = 1'b0; fifo_rdata = 8'h9E;
    rd(3'd5); chk(c_rd == 8'h61, "R9 data ready", c_rd, 8'h61);
    rd(3'd0); chk(c_rd == 8'h9E && c_pop, "R10 pop", {c_pop, c_rd}, 9'h19E);
    fifo_empty = 1'b1;
    rd(3'd0); chk(c_rd == 8'h00 && !c_pop, "R10 empty", {c_pop, c_rd}, 9'h000);
    fifo_empty = 1'b0;
    wr(3'd3, 8'h80);
    rd(3'd0); chk(c_rd == 8'h34 && !c_pop, "R2 latch read no pop", {c_pop, c_rd}, 9'h034);
    loop_en = 1'b1;
    wr(3'd0, 8'h07);
    chk(!c_push && divisor == 16'h1207, "R2 latch write no push", {c_push, divisor}, 17'h01207);

    // R1 reset again
    rst_n = 1'b0; #3; rst_n = 1'b1;
    @(negedge clk);
    chk(divisor == 16'h0001 && line_ctl == 8'h00, "R1 re-reset", divisor, 16'h0001);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule